// File: doc/BRIEF.md
# Write-Activity Status Flag Timer

This block produces a 32-bit status word whose low flags describe how recently an external FIFO bus was written. Each pulse on the write strobe arms or pushes out deadlines, measured in clock ticks against a free-running tick counter. Three flags follow different on-delay and off-delay rules. The recent flag (bit 5) restarts on every write. The settle flag (bit 4) and the drain flag (bit 0) build up their off time cumulatively when writes arrive back to back.

A read strobe samples the status view into the output register. The view is the stored status word with bits 5, 4 and 0 replaced by the live flag values. The stored word comes from a reset constant, and each write also sets its bit 5. Each flag has its own lane state machine with three states: Idle, Wait and Show. The transitions are:
- arm: a write while the lane is Idle, or while its off time is already behind the tick counter. It goes to Wait, or straight to Show when the on-delay is zero.
- reveal: Wait goes to Show once the on time is reached.
- retire: Wait or Show goes back to Idle once the off time is strictly behind the counter.
- extend: a write while the lane is live keeps the current state and moves only the off time.

All time comparisons subtract and test the sign, so they stay correct when the counter wraps.

Top module: `wst_status_timer`

## Requirements
- R1: After reset `rd_data` is zero, every lane is Idle, and every flag reads 0 until a write arrives.
- R2: A read strobe in cycle r loads the status view into `rd_data`, visible from the next cycle. `rd_data` holds its value in every cycle without a read strobe.
- R3: Bit 5 reads 1 for reads 1 to 7 ticks after the most recent write, and reads 0 from 8 ticks after it. Every write restarts this window.
- R4: A write at tick t that finds bit 4 expired (off time strictly before t) sets its on time to t+8 and its off time to t+16. Bit 4 then reads 1 exactly for reads at t+8 through t+15.
- R5: A write at a tick at or before bit 4's off time adds 16 ticks to that off time and leaves the on time alone. Bit 4 reads 1 only when its on time has passed, the off time has not yet come, and the off time is at most 8 ticks ahead.
- R6: A write at tick t that finds bit 0 expired (off time strictly before t) makes bit 0 read 1 for reads at t+24 through t+47.
- R7: A write at a tick at or before bit 0's off time, including exactly at it, adds 24 ticks to the off time and leaves the on time alone.
- R8: Every `rd_data` bit other than 5, 4 and 0 equals the matching bit of `STATUS_INIT`. Bits 5, 4 and 0 always show the flags, whatever the stored word holds.
- R9: All windows behave the same when the tick counter wraps through zero (start value `TICK_START`).
- R10: Bits 4 and 5 of the view are never 1 together.
- R11: When a read and a write hit the same cycle, the read reports the flags as they were before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse per bus write |
| rd_stb | input | 1 | Samples the status view into `rd_data` |
| rd_data | output | STATUS_W | Last sampled status word |

## Verification
The hardest case is a write that lands exactly on a lane's off tick. The flag already reads 0 there, but the lane is still live, so the write must extend the off time rather than arm the lane again. The bench tracks the tick of every edge it drives and places a combined read and write pulse on that exact tick, then probes the following ticks. This separates extend from arm and also covers the pre-write view of a same-cycle read. A second instance, whose counter starts just below the wrap point, receives the same stimulus, so every window is also checked across the wrap.

// File: rtl/wst_pkg.sv
`timescale 1ns/1ps
package wst_pkg;
    localparam int TICK_W     = 32;
    localparam int NUM_LANES  = 3;
    localparam int RECENT_BIT = 5;
    localparam int SETTLE_BIT = 4;
    localparam int DRAIN_BIT  = 0;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_WAIT = 2'd1,
        LN_SHOW = 2'd2
    } lane_st_e;

    typedef enum logic {
        EXT_RESTART = 1'b0,
        EXT_ACCUM   = 1'b1
    } ext_mode_e;

    // true when tick a lies strictly before tick b (wrap-safe)
    function automatic logic tick_before(input logic [TICK_W-1:0] a,
                                         input logic [TICK_W-1:0] b);
        logic [TICK_W-1:0] diff;
        diff = a - b;
        return diff[TICK_W-1];
    endfunction

    function automatic int lane_bit(input int idx);
        return (idx == 0) ? RECENT_BIT : (idx == 1) ? SETTLE_BIT : DRAIN_BIT;
    endfunction
endpackage

// File: rtl/wst_tick.sv
`timescale 1ns/1ps
module wst_tick #(
    parameter int          W     = 32,
    parameter logic [W-1:0] START = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] now
);
    always_ff @(posedge clk) begin
        if (!rst_n) now <= START;
        else        now <= now + W'(1);
    end
endmodule

// File: rtl/wst_lane.sv
`timescale 1ns/1ps
module wst_lane
    import wst_pkg::*;
#(
    parameter int        ON_DLY      = 8,
    parameter int        OFF_DLY     = 16,
    parameter int        WIN         = 0,
    parameter bit        OFF_FROM_ON = 1'b0,
    parameter ext_mode_e MODE        = EXT_ACCUM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] now,
    input  logic              wr,
    output logic              flag
);
    localparam logic [TICK_W-1:0] ON_T    = TICK_W'(ON_DLY);
    localparam logic [TICK_W-1:0] OFF_T   = TICK_W'(OFF_DLY);
    localparam logic [TICK_W-1:0] WIN_T   = TICK_W'(WIN);
    localparam logic [TICK_W-1:0] FRESH_T = OFF_FROM_ON ? TICK_W'(ON_DLY + OFF_DLY) : TICK_W'(OFF_DLY);
    localparam lane_st_e          ARM_ST  = (ON_DLY == 0) ? LN_SHOW : LN_WAIT;

    lane_st_e          st_q, st_d;
    logic [TICK_W-1:0] on_q, on_d, off_q, off_d;
    logic              fresh, off_gone, on_come, in_win;

    assign off_gone = tick_before(off_q, now);
    assign on_come  = !tick_before(now, on_q);
    assign fresh    = (st_q == LN_IDLE) || off_gone;

    // state and deadline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LN_IDLE;
            on_q  <= '0;
            off_q <= '0;
        end else begin
            st_q  <= st_d;
            on_q  <= on_d;
            off_q <= off_d;
        end
    end

    // next state: arm, reveal, retire, extend
    always_comb begin
        st_d  = st_q;
        on_d  = on_q;
        off_d = off_q;
        if (wr) begin
            if (fresh) begin
                on_d  = now + ON_T;
                off_d = now + FRESH_T;
                st_d  = ARM_ST;
            end else if (MODE == EXT_ACCUM) begin
                off_d = off_q + OFF_T;
            end else begin
                off_d = now + OFF_T;
            end
        end else begin
            unique case (st_q)
                LN_IDLE: st_d = LN_IDLE;
                LN_WAIT: begin
                    if (off_gone)     st_d = LN_IDLE;
                    else if (on_come) st_d = LN_SHOW;
                end
                LN_SHOW: if (off_gone) st_d = LN_IDLE;
                default: st_d = LN_IDLE;
            endcase
        end
    end

    // output: flag view from deadlines against the current tick
    always_comb begin
        in_win = (WIN == 0) ? 1'b1 : !tick_before(now + WIN_T, off_q);
        flag   = (st_q != LN_IDLE) && tick_before(now, off_q) && on_come && in_win;
    end

    // R3
    lane_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (st_q != LN_IDLE));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_IDLE) && !wr |=> (st_q == LN_IDLE) && !flag);

    generate
        if (MODE == EXT_ACCUM) begin : g_acc
            // R7
            accum_later_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr && !fresh |=> tick_before($past(off_q), off_q));
        end
    endgenerate
endmodule

// File: rtl/wst_status_timer.sv
`timescale 1ns/1ps
module wst_status_timer
    import wst_pkg::*;
#(
    parameter int                  STATUS_W    = 32,
    parameter logic [STATUS_W-1:0] STATUS_INIT = '0,
    parameter logic [TICK_W-1:0]   TICK_START  = '0,
    parameter int                  RECENT_OFF  = 8,
    parameter int                  SETTLE_ON   = 8,
    parameter int                  SETTLE_OFF  = 16,
    parameter int                  SETTLE_WIN  = 8,
    parameter int                  DRAIN_ON    = 24,
    parameter int                  DRAIN_OFF   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic                rd_stb,
    output logic [STATUS_W-1:0] rd_data
);
    logic [TICK_W-1:0]    now;
    logic [NUM_LANES-1:0] lane_flag;
    logic [STATUS_W-1:0]  stored_q;
    logic [STATUS_W-1:0]  view;

    wst_tick #(.W(TICK_W), .START(TICK_START)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            localparam int        L_ON   = (g == 0) ? 0 : (g == 1) ? SETTLE_ON : DRAIN_ON;
            localparam int        L_OFF  = (g == 0) ? RECENT_OFF : (g == 1) ? SETTLE_OFF : DRAIN_OFF;
            localparam int        L_WIN  = (g == 1) ? SETTLE_WIN : 0;
            localparam bit        L_FROM = (g == 2);
            localparam ext_mode_e L_MODE = (g == 0) ? EXT_RESTART : EXT_ACCUM;
            wst_lane #(
                .ON_DLY      (L_ON),
                .OFF_DLY     (L_OFF),
                .WIN         (L_WIN),
                .OFF_FROM_ON (L_FROM),
                .MODE        (L_MODE)
            ) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .now   (now),
                .wr    (wr_stb),
                .flag  (lane_flag[g])
            );
        end
    endgenerate

    // stored word: reset constant, write marks the recent bit
    always_ff @(posedge clk) begin
        if (!rst_n)      stored_q <= STATUS_INIT;
        else if (wr_stb) stored_q <= stored_q | (STATUS_W'(1) << RECENT_BIT);
    end

    always_comb begin
        view = stored_q;
        for (int i = 0; i < NUM_LANES; i++) begin
            view[lane_bit(i)] = lane_flag[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= view;
    end

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(view[SETTLE_BIT] && view[RECENT_BIT]));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R3
    recent_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> view[RECENT_BIT]);
endmodule

// File: tb/test_wst_status_timer.sv
`timescale 1ns/1ps
module test_wst_status_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] data, data_w;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wst_status_timer #(.STATUS_INIT(32'hC0DE_0031)) i_wst_status_timer (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr), .rd_stb(rd), .rd_data(data)
    );

    wst_status_timer #(.TICK_START(32'hFFFF_FFE8)) i_wst_status_timer_wrap (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr), .rd_stb(rd), .rd_data(data_w)
    );

    task automatic chk_bit(input int pos, input logic exp, input string tag);
        total++;
        if (data[pos] !== exp) begin
            bad++;
            $display("FAIL %s: bit %0d got %b expected %b (tick %0d)", tag, pos, data[pos], exp, cyc);
        end
        total++;
        if (data_w[pos] !== exp) begin
            bad++;
            $display("FAIL R9 (%s): wrapped bit %0d got %b expected %b", tag, pos, data_w[pos], exp);
        end
    endtask

    task automatic chk_word(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: word got %h expected %h", tag, got, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic pulse(input logic w, input logic r);
        wr = w;
        rd = r;
        @(negedge clk);
        wr = 1'b0;
        rd = 1'b0;
    endtask

    task automatic wait_before(input int tgt);
        while (cyc + 1 < tgt) @(negedge clk);
    endtask

    task automatic write_now(output int t);
        pulse(1'b1, 1'b0);
        t = cyc;
    endtask

    task automatic write_at(input int tgt);
        wait_before(tgt);
        pulse(1'b1, 1'b0);
    endtask

    task automatic read_at(input int tgt);
        wait_before(tgt);
        pulse(1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk_word(data, 32'h0, "R1 main after reset");
        chk_word(data_w, 32'h0, "R1 wrap after reset");
        read_at(cyc + 3);
        chk_word(data, 32'hC0DE_0000, "R8 idle view, flags override stored bits");
        chk_word(data_w, 32'h0, "R1 idle flags");
    endtask

    task automatic t_recent();
        int t;
        do_reset();
        write_now(t);
        read_at(t + 1);  chk_bit(5, 1'b1, "R3 +1");
        read_at(t + 7);  chk_bit(5, 1'b1, "R3 +7");
        read_at(t + 8);  chk_bit(5, 1'b0, "R3 +8");
        write_now(t);
        write_at(t + 5);
        read_at(t + 12); chk_bit(5, 1'b1, "R3 restart +7");
        read_at(t + 13); chk_bit(5, 1'b0, "R3 restart +8");
    endtask

    task automatic t_same_cycle();
        int t;
        do_reset();
        pulse(1'b1, 1'b1);
        t = cyc;
        chk_bit(5, 1'b0, "R11 read sees pre-write bit5");
        chk_bit(0, 1'b0, "R11 read sees pre-write bit0");
        read_at(t + 1);  chk_bit(5, 1'b1, "R11 next read");
    endtask

    task automatic t_settle_fresh();
        int t;
        do_reset();
        write_now(t);
        read_at(t + 7);  chk_bit(4, 1'b0, "R4 +7");
        read_at(t + 8);  chk_bit(4, 1'b1, "R4 +8");
        chk_bit(5, 1'b0, "R10 bit5 clear while bit4 set");
        read_at(t + 15); chk_bit(4, 1'b1, "R4 +15");
        read_at(t + 16); chk_bit(4, 1'b0, "R4 +16");
    endtask

    task automatic t_settle_accum();
        int t;
        do_reset();
        write_now(t);
        write_at(t + 4);
        read_at(t + 10); chk_bit(4, 1'b0, "R5 outside window");
        read_at(t + 23); chk_bit(4, 1'b0, "R5 +23");
        read_at(t + 24); chk_bit(4, 1'b1, "R5 +24");
        read_at(t + 31); chk_bit(4, 1'b1, "R5 +31");
        read_at(t + 32); chk_bit(4, 1'b0, "R5 +32");
    endtask

    task automatic t_drain_fresh();
        int t;
        do_reset();
        write_now(t);
        read_at(t + 23); chk_bit(0, 1'b0, "R6 +23");
        read_at(t + 24); chk_bit(0, 1'b1, "R6 +24");
        read_at(t + 47); chk_bit(0, 1'b1, "R6 +47");
        read_at(t + 48); chk_bit(0, 1'b0, "R6 +48");
    endtask

    task automatic t_drain_extend();
        int t;
        do_reset();
        write_now(t);
        write_at(t + 10);
        read_at(t + 71); chk_bit(0, 1'b1, "R7 extended +71");
        read_at(t + 72); chk_bit(0, 1'b0, "R7 extended +72");
    endtask

    task automatic t_drain_edge();
        int t;
        do_reset();
        write_now(t);
        wait_before(t + 48);
        pulse(1'b1, 1'b1);
        chk_bit(0, 1'b0, "R7 read at off tick");
        read_at(t + 49); chk_bit(0, 1'b1, "R7 write at off tick extends");
        read_at(t + 72); chk_bit(0, 1'b0, "R7 extended off");
    endtask

    task automatic t_drain_rearm();
        int t;
        do_reset();
        write_now(t);
        write_at(t + 49);
        read_at(t + 72); chk_bit(0, 1'b0, "R6 rearm before on");
        read_at(t + 73); chk_bit(0, 1'b1, "R6 rearm on");
    endtask

    task automatic t_hold();
        int t;
        logic [31:0] snap;
        do_reset();
        write_now(t);
        read_at(t + 1);
        snap = data;
        chk_bit(5, 1'b1, "R2 sampled");
        wait_before(t + 30);
        chk_word(data, snap, "R2 hold without read");
    endtask

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_recent();
        t_same_cycle();
        t_settle_fresh();
        t_settle_accum();
        t_drain_fresh();
        t_drain_extend();
        t_drain_edge();
        t_drain_rearm();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule